// File: doc/BRIEF.md
# Byte-Serial Reflected CRC-32 Engine with Self-Built Lookup Table

This block computes the reflected 32-bit CRC (generator 0xEDB88320 in reversed bit order, preset all ones, final inversion) of a byte stream at one byte per clock. Each byte is folded into the running remainder through a 256-word lookup table. The index is the low byte of the remainder XOR the incoming byte. The next remainder is the old remainder shifted right by eight, XOR the table word at that index.

The table is not loaded from outside. After reset a small generator writes it, one word per clock. Entry 0 is zero. The generator then steps a working value one reflected bit at a time for the single-bit indices 128, 64, …, 1, and stores each result. Every other entry comes from the linearity rule: the entry at i XOR j is the entry at i XOR the entry at j. The whole fill takes exactly 256 clocks. Until it ends, `table_ready` is low and every control and data input is ignored.

A user pulses `start` to open a message, presents bytes with `byte_valid`, and pulses `finish` to take the result. `finish` may share a cycle with the last byte, and `start` may share a cycle with the first byte.

Top module: `crc32_table_engine`

## Requirements
- R1: For every byte value b, a message made of the single byte b yields the bit-at-a-time reflected CRC-32 of b. This proves that each of the 256 table words is correct.
- R2: After reset is released, `table_ready` stays low for exactly 256 rising clock edges, is high after the 256th, and then stays high until the next reset.
- R3: While `table_ready` is low, `start`, `byte_valid` and `finish` have no effect. No `crc_valid` pulse occurs, and the remainder keeps its preset value. A `finish` given alone right after the table is ready therefore returns 0x00000000.
- R4: Bytes presented on consecutive cycles are each folded in, one per clock. Cycles with `byte_valid` low leave the remainder unchanged.
- R5: `start` reloads the remainder with 0xFFFFFFFF and discards any unfinished message. A byte in the same cycle as `start` becomes the first byte of the new message.
- R6: A `finish` accepted on a clock edge sets `crc_out` to the bitwise inverse of the remainder, including any byte accepted on that same edge. `crc_valid` is high for exactly the one following cycle.
- R7: The ASCII message "123456789" (bytes 0x31 to 0x39) gives 0xCBF43926.
- R8: An empty message (`start` then `finish` with no bytes, in separate cycles or the same cycle) gives 0x00000000.
- R9: `crc_out` keeps its last result until the next accepted `finish`, even while a new message is being fed. It is 0 after reset.
- R10: Messages of random length and content, with random idle cycles between bytes, match the bit-at-a-time reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts table fill |
| start | input | 1 | Reload remainder with the preset |
| byte_valid | input | 1 | `byte_in` carries a message byte this cycle |
| byte_in | input | 8 | Message byte |
| finish | input | 1 | Close the message and publish the result |
| table_ready | output | 1 | Table fill complete; inputs accepted |
| crc_out | output | 32 | Last published CRC (inverted remainder) |
| crc_valid | output | 1 | One-cycle pulse: `crc_out` was just updated |

## Verification
The assertions check, on every cycle, the timing aspects. `table_ready` must rise on exactly the 256th edge and stay high. `crc_valid` must follow each accepted `finish` by one cycle and never appear otherwise. `crc_out` must hold still outside that pulse. The numeric correctness of the table and of the running remainder can only be shown by the bench's scenarios: the sweep over all 256 single-byte messages, the "123456789" check value, empty messages, restarts in mid-message, and random messages with gaps, all compared against an independent bit-serial model.

// File: rtl/crc32_tbl_pkg.sv
`timescale 1ns/1ps
package crc32_tbl_pkg;
    localparam int CRC_W  = 32;
    localparam int SYM_W  = 8;
    localparam int DEPTH  = 1 << SYM_W;
    localparam int CNT_W  = SYM_W + 1;

    localparam logic [CRC_W-1:0] POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] PRESET    = '1;
    localparam logic [CRC_W-1:0] OUT_MASK  = '1;

    typedef logic [CRC_W-1:0] crc_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [1:0] {
        GEN_ZERO,
        GEN_FILL,
        GEN_DONE
    } gen_state_e;

    typedef struct packed {
        logic en;
        sym_t addr;
        crc_t data;
    } tbl_wr_t;

    // One reflected division step: shift toward LSB, fold generator on carry-out.
    function automatic crc_t refl_step(input crc_t v);
        return v[0] ? ((v >> 1) ^ POLY_REFL) : (v >> 1);
    endfunction
endpackage

// File: rtl/crc32_tbl_gen.sv
`timescale 1ns/1ps
module crc32_tbl_gen
    import crc32_tbl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  crc_t    rd_data,
    output sym_t    rd_addr,
    output tbl_wr_t wr,
    output logic    done
);
    gen_state_e state_q;
    sym_t       stage_bit_q;   // one-hot index of the entry computed directly
    sym_t       base_q;        // already-filled partner index (multiple of 2*stage)
    crc_t       work_q;        // table word for stage_bit_q

    logic [SYM_W:0] base_next;

    assign base_next = {1'b0, base_q} + {stage_bit_q, 1'b0};
    assign rd_addr   = base_q;
    assign done      = (state_q == GEN_DONE);

    always_comb begin
        wr.en   = 1'b0;
        wr.addr = '0;
        wr.data = '0;
        case (state_q)
            GEN_ZERO: wr.en = 1'b1;
            GEN_FILL: begin
                wr.en   = 1'b1;
                wr.addr = stage_bit_q | base_q;
                wr.data = work_q ^ rd_data;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= GEN_ZERO;
            stage_bit_q <= '0;
            base_q      <= '0;
            work_q      <= '0;
        end else begin
            case (state_q)
                GEN_ZERO: begin
                    state_q     <= GEN_FILL;
                    stage_bit_q <= sym_t'(1) << (SYM_W - 1);
                    base_q      <= '0;
                    work_q      <= refl_step(crc_t'(1));
                end
                GEN_FILL: begin
                    if (base_next[SYM_W]) begin
                        if (stage_bit_q[0]) begin
                            state_q <= GEN_DONE;
                        end else begin
                            stage_bit_q <= stage_bit_q >> 1;
                            base_q      <= '0;
                            work_q      <= refl_step(work_q);
                        end
                    end else begin
                        base_q <= base_next[SYM_W-1:0];
                    end
                end
                default: state_q <= GEN_DONE;
            endcase
        end
    end
endmodule

// File: rtl/crc32_tbl_store.sv
`timescale 1ns/1ps
module crc32_tbl_store
    import crc32_tbl_pkg::*;
(
    input  logic    clk,
    input  tbl_wr_t wr,
    input  sym_t    gen_addr,
    output crc_t    gen_data,
    input  sym_t    lk_addr,
    output crc_t    lk_data
);
    crc_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.data;
    end

    assign gen_data = mem[gen_addr];
    assign lk_data  = mem[lk_addr];
endmodule

// File: rtl/crc32_tbl_core.sv
`timescale 1ns/1ps
module crc32_tbl_core
    import crc32_tbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ready,
    input  logic start,
    input  logic byte_valid,
    input  sym_t byte_in,
    input  logic finish,
    output sym_t lk_addr,
    input  crc_t lk_data,
    output crc_t crc_out,
    output logic crc_valid
);
    crc_t rem_q;
    crc_t rem_base;
    crc_t rem_next;

    always_comb begin
        rem_base = start ? PRESET : rem_q;
        lk_addr  = rem_base[SYM_W-1:0] ^ byte_in;
        rem_next = byte_valid ? ((rem_base >> SYM_W) ^ lk_data) : rem_base;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q     <= PRESET;
            crc_out   <= '0;
            crc_valid <= 1'b0;
        end else begin
            crc_valid <= ready && finish;
            if (ready) begin
                rem_q <= rem_next;
                if (finish) crc_out <= rem_next ^ OUT_MASK;
            end
        end
    end
endmodule

// File: rtl/crc32_table_engine.sv
`timescale 1ns/1ps
module crc32_table_engine
    import crc32_tbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             byte_valid,
    input  logic [SYM_W-1:0] byte_in,
    input  logic             finish,
    output logic             table_ready,
    output logic [CRC_W-1:0] crc_out,
    output logic             crc_valid
);
    tbl_wr_t wr;
    sym_t    gen_addr;
    crc_t    gen_data;
    sym_t    lk_addr;
    crc_t    lk_data;

    crc32_tbl_gen u_gen (
        .clk     (clk),
        .rst     (rst),
        .rd_data (gen_data),
        .rd_addr (gen_addr),
        .wr      (wr),
        .done    (table_ready)
    );

    crc32_tbl_store u_store (
        .clk      (clk),
        .wr       (wr),
        .gen_addr (gen_addr),
        .gen_data (gen_data),
        .lk_addr  (lk_addr),
        .lk_data  (lk_data)
    );

    crc32_tbl_core u_core (
        .clk        (clk),
        .rst        (rst),
        .ready      (table_ready),
        .start      (start),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .finish     (finish),
        .lk_addr    (lk_addr),
        .lk_data    (lk_data),
        .crc_out    (crc_out),
        .crc_valid  (crc_valid)
    );
endmodule

// File: rtl/crc32_table_engine_chk.sv
`timescale 1ns/1ps
module crc32_table_engine_chk
    import crc32_tbl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             finish,
    input logic             table_ready,
    input logic [CRC_W-1:0] crc_out,
    input logic             crc_valid
);
    logic [CNT_W-1:0] edges_q;

    always_ff @(posedge clk) begin
        if (rst) edges_q <= '0;
        else if (edges_q != CNT_W'(DEPTH)) edges_q <= edges_q + 1'b1;
    end

    // R2
    ready_timing_chk: assert property (@(posedge clk) disable iff (rst)
        table_ready == (edges_q == CNT_W'(DEPTH)));

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        table_ready |=> table_ready);

    // R3
    valid_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        crc_valid |-> table_ready);

    // R6
    finish_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && table_ready) |=> crc_valid);

    // R6
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        crc_valid |-> $past(finish && table_ready));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !crc_valid |-> $stable(crc_out));
endmodule

bind crc32_table_engine crc32_table_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .finish      (finish),
    .table_ready (table_ready),
    .crc_out     (crc_out),
    .crc_valid   (crc_valid)
);

// File: tb/crc32_table_engine_tb.sv
`timescale 1ns/1ps
module crc32_table_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        finish = 1'b0;
    logic        table_ready;
    logic [31:0] crc_out;
    logic        crc_valid;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] last_exp = '0;

    always #2 clk = ~clk;

    crc32_table_engine u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .byte_valid  (byte_valid),
        .byte_in     (byte_in),
        .finish      (finish),
        .table_ready (table_ready),
        .crc_out     (crc_out),
        .crc_valid   (crc_valid)
    );

    function automatic logic [31:0] ref_crc(input logic [7:0] m[$]);
        logic [31:0] c = 32'hFFFFFFFF;
        foreach (m[k]) begin
            c ^= {24'h0, m[k]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit s, input bit v, input logic [7:0] b, input bit f);
        @(negedge clk);
        start = s; byte_valid = v; byte_in = b; finish = f;
    endtask

    task automatic push(input logic [31:0] v, input string tag);
        exp_t e;
        e.val = v; e.tag = tag;
        sb.push_back(e);
        last_exp = v;
    endtask

    task automatic send_msg(input logic [7:0] m[$], input logic [31:0] exp, input string tag,
                            input bit join_start, input bit join_finish, input bit gaps);
        push(exp, tag);
        if (!join_start) cyc(1, 0, 8'h00, 0);
        foreach (m[k]) begin
            if (gaps && ($urandom % 3 == 0)) cyc(0, 0, 8'($urandom), 0);
            cyc(join_start && k == 0, 1, m[k], join_finish && (k == m.size() - 1));
        end
        if (!join_finish) cyc(0, 0, 8'h00, 1);
        cyc(0, 0, 8'h00, 0);
    endtask

    // Monitor: pops the scoreboard on each result pulse.
    always @(negedge clk) begin
        if (!rst && crc_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected crc_valid", crc_out, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(crc_out === e.val, e.tag, crc_out, e.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] m[$];
        bit         quiet;

        repeat (3) @(negedge clk);
        // Reset state (R2, R9)
        check(table_ready == 1'b0, "R2 ready in reset", 32'(table_ready), 32'h0);
        check(crc_out == 32'h0 && crc_valid == 1'b0, "R9 reset outputs", crc_out, 32'h0);
        rst = 1'b0;

        // Table fill window: poke inputs (R3) and watch table_ready (R2)
        quiet = 1'b1;
        for (int t = 1; t <= 255; t++) begin
            @(negedge clk);
            if (table_ready !== 1'b0 || crc_valid !== 1'b0) quiet = 1'b0;
            if (t >= 20 && t < 30) begin
                start = 1'b1; byte_valid = 1'b1; byte_in = 8'(t * 37); finish = t[0];
            end else begin
                start = 1'b0; byte_valid = 1'b1; byte_in = 8'(t); finish = 1'b0;
            end
            if (t == 255) begin
                start = 1'b0; byte_valid = 1'b0; finish = 1'b0;
            end
        end
        check(quiet, "R2/R3 low ready and no pulse during fill", 32'(quiet), 32'h1);
        @(negedge clk);
        check(table_ready == 1'b1, "R2 ready after 256 edges", 32'(table_ready), 32'h1);

        // R3: earlier pokes left the preset in place
        push(32'h0, "R3 finish alone after fill");
        start = 1'b0; byte_valid = 1'b0; finish = 1'b1;
        cyc(0, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 0);

        // R1: every table word through single-byte messages
        for (int k = 0; k < 256; k++) begin
            m = {};
            m.push_back(8'(k) ^ 8'hFF);
            send_msg(m, ref_crc(m), "R1 table word", 1, 1, 0);
        end

        // R7: check value
        m = {};
        for (int k = 0; k < 9; k++) m.push_back(8'h31 + 8'(k));
        send_msg(m, 32'hCBF43926, "R7 check string", 0, 0, 0);
        check(ref_crc(m) == 32'hCBF43926, "R7 bench model", ref_crc(m), 32'hCBF43926);

        // R9: feeding a new message without finish keeps crc_out
        cyc(1, 1, 8'hA5, 0);
        cyc(0, 1, 8'h5A, 0);
        cyc(0, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 0);
        check(crc_out == 32'hCBF43926, "R9 hold during feed", crc_out, 32'hCBF43926);

        // R5: restart discards partial data; start shares cycle with first byte
        m = {8'hDE, 8'hAD, 8'hBE, 8'hEF};
        send_msg(m, ref_crc(m), "R5 restart joined", 1, 0, 0);
        cyc(1, 1, 8'h11, 0);
        cyc(0, 1, 8'h22, 0);
        send_msg(m, ref_crc(m), "R5 restart separate", 0, 1, 0);

        // R8: empty messages
        push(32'h0, "R8 empty joined");
        cyc(1, 0, 8'h00, 1);
        cyc(0, 0, 8'h00, 0);
        push(32'h0, "R8 empty separate");
        cyc(1, 0, 8'h00, 0);
        cyc(0, 0, 8'h00, 1);
        cyc(0, 0, 8'h00, 0);

        // R4: back-to-back bytes, and gapped version of same data
        m = {};
        for (int k = 0; k < 32; k++) m.push_back(8'(k * 11 + 3));
        send_msg(m, ref_crc(m), "R4 back-to-back", 1, 1, 0);
        send_msg(m, ref_crc(m), "R4 with idle gaps", 0, 0, 1);

        // R10: random messages
        for (int n = 0; n < 40; n++) begin
            int len;
            len = 1 + int'($urandom % 48);
            m = {};
            for (int k = 0; k < len; k++) m.push_back(8'($urandom));
            send_msg(m, ref_crc(m), "R10 random message", n[0], n[1], 1);
        end

        repeat (4) cyc(0, 0, 8'h00, 0);
        check(sb.size() == 0, "R6 every finish produced a pulse", 32'(sb.size()), 32'h0);
        check(crc_out == last_exp, "R9 hold at end", crc_out, last_exp);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule